// File: doc/BRIEF.md
# Banked Prioritized Interrupt Controller

This block collects up to 128 level-sensitive interrupt lines, grouped in banks of 32, and presents one winning line to each of two processor interrupt outputs: a normal interrupt (irq) and a fast interrupt (fiq). Every line has a mask bit and a software-trigger bit. It also has a level word that gives it a 6-bit priority and selects which of the two outputs it is routed to.

Software programs the block through a simple 32-bit register port with a single-cycle write strobe and a combinational read. Among all pending lines routed to an output, the line with the numerically lowest priority wins. Once chosen, the winner is latched and its output is asserted. Both stay fixed until software writes the matching re-arm bit in the control register, which lets the handler read a stable line number while inputs keep moving. A soft reset command returns the programmable state to its reset values and reports completion through a status bit.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After the reset input is released, irq_o and fiq_o are 0 and every mask bit is 1. Both active-line registers (0x40 normal, 0x44 fast) read 0x80, and the status register (0x14) reads 1.
- R2: Each bank n that exists has words at 0x80+0x20*n. Writing +0x04 loads the mask directly. Writing 1 bits to +0x08 clears those mask bits and writing 1 bits to +0x0C sets them. Zero bits written to either alias change nothing. Reading +0x04 returns the mask, and a mask bit of 1 blocks its line.
- R3: Writing 1 bits to the bank word +0x10 sets software triggers, and writing 1 bits to +0x14 clears them. Reading +0x10 returns the triggers. A triggered line behaves exactly as if its input were high.
- R4: A line is pending when its input or its trigger is 1 and its mask bit is 0. Bank word +0x18 shows the pending lines routed to irq, +0x1C the pending lines routed to fiq, and +0x00 shows the raw inputs.
- R5: When a latch happens, the winner is the pending line of lowest priority value among those routed to that output. On equal priority, the lower line number wins.
- R6: The level word of line L is at 0x100+4*L. Bits [7:2] hold the priority (0 is the highest), and bit 0 set routes the line to fiq. Bit 1 and bits [31:8] read 0.
- R7: While an output's winner is held, its active-line register and its output stay unchanged, even when inputs, masks or priorities change. Reading the active register returns the line number while held and 0x80 while nothing is held.
- R8: Writing 1 to bit 0 of the control register (0x48) releases the irq winner, and writing 1 to bit 1 releases the fiq winner. The released output is 0 in the next cycle. One cycle later, a new winner is latched if a line is pending, and the output rises together with the latch.
- R9: Writing 1 to bit 1 of the config register (0x10) starts a soft reset. The status register reads 0 in the cycle that follows and 1 after that. The soft reset sets all masks, clears all triggers and level words, and drops both outputs.
- R10: The revision register (0x00) reads the major version in bits [7:4] and the minor version in bits [3:0], with both set by parameters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe, one cycle per write |
| addr_i | input | 10 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| lines_i | input | NUM_LINES | Level-sensitive interrupt inputs |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The hardest case to create is a winner that is held while the pending set moves under it: a better line arrives, or the held line drops, between the latch and the re-arm. The bench creates this on purpose. It latches a line, then raises a lower-numbered line of equal priority, checks that nothing moves, and re-arms to see the new line taken. Random rounds limit priorities to four values to force many ties across banks. Each round starts from a re-arm, so every latch is compared against a freshly computed winner.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned BANK_W  = 32;
  localparam int unsigned PRI_W   = 6;
  localparam int unsigned ADDR_W  = 10;
  localparam logic [ADDR_W-1:0] OFS_REV  = 10'h000;
  localparam logic [ADDR_W-1:0] OFS_CFG  = 10'h010;
  localparam logic [ADDR_W-1:0] OFS_STAT = 10'h014;
  localparam logic [ADDR_W-1:0] OFS_AIRQ = 10'h040;
  localparam logic [ADDR_W-1:0] OFS_AFIQ = 10'h044;
  localparam logic [ADDR_W-1:0] OFS_CTL  = 10'h048;
  localparam logic [31:0]       NONE_ID  = 32'h80;
  // word index within a bank block
  typedef enum logic [2:0] {
    BW_RAW  = 3'd0, BW_MASK = 3'd1, BW_MCLR = 3'd2, BW_MSET = 3'd3,
    BW_SSET = 3'd4, BW_SCLR = 3'd5, BW_PIRQ = 3'd6, BW_PFIQ = 3'd7
  } bank_word_e;
endpackage

// File: rtl/pic_bank.sv
module pic_bank import pic_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_mask_i,
  input  logic              wr_mclr_i,
  input  logic              wr_mset_i,
  input  logic              wr_sset_i,
  input  logic              wr_sclr_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [BANK_W-1:0] mask_o,
  output logic [BANK_W-1:0] trig_o
);
  logic [BANK_W-1:0] mask_q, trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      trig_q <= '0;
    end else if (clr_i) begin
      mask_q <= '1;
      trig_q <= '0;
    end else begin
      if (wr_mask_i)      mask_q <= wdata_i;
      else if (wr_mclr_i) mask_q <= mask_q & ~wdata_i;
      else if (wr_mset_i) mask_q <= mask_q | wdata_i;
      if (wr_sset_i)      trig_q <= trig_q | wdata_i;
      else if (wr_sclr_i) trig_q <= trig_q & ~wdata_i;
    end
  end

  assign mask_o = mask_q;
  assign trig_o = trig_q;
endmodule

// File: rtl/pic_arb.sv
module pic_arb #(
  parameter int unsigned N     = 96,
  parameter int unsigned PRI_W = 6,
  parameter int unsigned ID_W  = 7
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic                      rearm_i,
  input  logic [N-1:0]              pend_i,
  input  logic [N-1:0][PRI_W-1:0]   pri_i,
  output logic                      held_o,
  output logic [ID_W-1:0]           id_o
);
  logic             found;
  logic [PRI_W-1:0] best_pri;
  logic [ID_W-1:0]  best_id;
  logic             held_q;
  logic [ID_W-1:0]  id_q;

  // ascending scan with strict compare: ties keep the lower line
  always_comb begin
    found    = 1'b0;
    best_pri = '1;
    best_id  = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (pend_i[i] && (!found || pri_i[i] < best_pri)) begin
        found    = 1'b1;
        best_pri = pri_i[i];
        best_id  = ID_W'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= 1'b0;
      id_q   <= '0;
    end else if (clr_i || rearm_i) begin
      held_q <= 1'b0;
    end else if (!held_q && found) begin
      held_q <= 1'b1;
      id_q   <= best_id;
    end
  end

  assign held_o = held_q;
  assign id_o   = id_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl import pic_pkg::*; #(
  parameter int unsigned NUM_LINES = 96,
  parameter logic [3:0]  REV_MAJOR = 4'd5,
  parameter logic [3:0]  REV_MINOR = 4'd0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  input  logic [NUM_LINES-1:0] lines_i,
  output logic                 irq_o,
  output logic                 fiq_o
);
  localparam int unsigned NUM_BANKS = NUM_LINES / BANK_W;
  localparam int unsigned ID_W      = $clog2(NUM_LINES);

  logic                            srst_busy;
  logic [NUM_LINES-1:0]            mask_all, trig_all, fsel_q;
  logic [NUM_LINES-1:0][PRI_W-1:0] pri_q;
  logic [NUM_LINES-1:0]            pend, pend_irq, pend_fiq;
  logic [ID_W-1:0]                 irq_id, fiq_id;
  logic                            irq_held, fiq_held;

  // address decode
  logic       bank_hit, lvl_hit, wr_ctl, srst_req;
  logic [1:0] bsel;
  bank_word_e bword;
  logic [7:0] lidx;

  assign bank_hit = (addr_i[9:7] == 3'b001);
  assign bsel     = addr_i[6:5];
  assign bword    = bank_word_e'(addr_i[4:2]);
  assign lvl_hit  = (addr_i[9:8] != 2'b00);
  assign lidx     = addr_i[9:2] - 8'd64;
  assign wr_ctl   = we_i && (addr_i == OFS_CTL);
  assign srst_req = we_i && (addr_i == OFS_CFG) && wdata_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) srst_busy <= 1'b0;
    else         srst_busy <= srst_req && !srst_busy;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bw;
    assign bw = we_i && bank_hit && (bsel == 2'(b));
    pic_bank u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (srst_busy),
      .wr_mask_i (bw && bword == BW_MASK),
      .wr_mclr_i (bw && bword == BW_MCLR),
      .wr_mset_i (bw && bword == BW_MSET),
      .wr_sset_i (bw && bword == BW_SSET),
      .wr_sclr_i (bw && bword == BW_SCLR),
      .wdata_i   (wdata_i),
      .mask_o    (mask_all[b*BANK_W +: BANK_W]),
      .trig_o    (trig_all[b*BANK_W +: BANK_W])
    );
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_lvl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pri_q[g]  <= '0;
        fsel_q[g] <= 1'b0;
      end else if (srst_busy) begin
        pri_q[g]  <= '0;
        fsel_q[g] <= 1'b0;
      end else if (we_i && lvl_hit && lidx == 8'(g)) begin
        pri_q[g]  <= wdata_i[7:2];
        fsel_q[g] <= wdata_i[0];
      end
    end
  end

  assign pend     = (lines_i | trig_all) & ~mask_all;
  assign pend_irq = pend & ~fsel_q;
  assign pend_fiq = pend & fsel_q;

  pic_arb #(.N(NUM_LINES), .PRI_W(PRI_W), .ID_W(ID_W)) u_arb_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (srst_busy),
    .rearm_i (wr_ctl && wdata_i[0]),
    .pend_i  (pend_irq),
    .pri_i   (pri_q),
    .held_o  (irq_held),
    .id_o    (irq_id)
  );

  pic_arb #(.N(NUM_LINES), .PRI_W(PRI_W), .ID_W(ID_W)) u_arb_fiq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (srst_busy),
    .rearm_i (wr_ctl && wdata_i[1]),
    .pend_i  (pend_fiq),
    .pri_i   (pri_q),
    .held_o  (fiq_held),
    .id_o    (fiq_id)
  );

  assign irq_o = irq_held;
  assign fiq_o = fiq_held;

  // read mux
  always_comb begin
    int base;
    base    = int'(bsel) * BANK_W;
    rdata_o = '0;
    if (addr_i == OFS_REV) begin
      rdata_o = {24'b0, REV_MAJOR, REV_MINOR};
    end else if (addr_i == OFS_STAT) begin
      rdata_o = {31'b0, !srst_busy};
    end else if (addr_i == OFS_AIRQ) begin
      rdata_o = irq_held ? 32'(irq_id) : NONE_ID;
    end else if (addr_i == OFS_AFIQ) begin
      rdata_o = fiq_held ? 32'(fiq_id) : NONE_ID;
    end else if (bank_hit && int'(bsel) < int'(NUM_BANKS)) begin
      case (bword)
        BW_RAW:  rdata_o = lines_i[base +: BANK_W];
        BW_MASK: rdata_o = mask_all[base +: BANK_W];
        BW_SSET: rdata_o = trig_all[base +: BANK_W];
        BW_SCLR: rdata_o = trig_all[base +: BANK_W];
        BW_PIRQ: rdata_o = pend_irq[base +: BANK_W];
        BW_PFIQ: rdata_o = pend_fiq[base +: BANK_W];
        default: rdata_o = '0;
      endcase
    end else if (lvl_hit && int'(lidx) < int'(NUM_LINES)) begin
      rdata_o = {24'b0, pri_q[ID_W'(lidx)], 1'b0, fsel_q[ID_W'(lidx)]};
    end
  end
endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
  parameter int unsigned N    = 96,
  parameter int unsigned ID_W = 7
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            we_i,
  input logic [9:0]      addr_i,
  input logic [31:0]     wdata_i,
  input logic            irq_o,
  input logic            fiq_o,
  input logic            srst_busy_i,
  input logic [ID_W-1:0] irq_id_i,
  input logic [N-1:0]    pend_irq_i,
  input logic [N-1:0]    mask_all_i
);
  logic rearm_irq, rearm_fiq;
  assign rearm_irq = we_i && addr_i == 10'h048 && wdata_i[0];
  assign rearm_fiq = we_i && addr_i == 10'h048 && wdata_i[1];

  p_rearm_drops_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_irq |=> !irq_o);

  p_rearm_drops_fiq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_fiq |=> !fiq_o);

  p_hold_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !rearm_irq && !srst_busy_i) |=> (irq_o && $stable(irq_id_i)));

  p_winner_was_pending_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ((($past(pend_irq_i) >> irq_id_i) & N'(1)) != '0));

  p_srst_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_busy_i |=> ((&mask_all_i) && !irq_o && !fiq_o));

  p_srst_one_cycle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_busy_i |=> !srst_busy_i);
endmodule

bind prio_irq_ctrl pic_checker #(.N(NUM_LINES), .ID_W(ID_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .irq_o       (irq_o),
  .fiq_o       (fiq_o),
  .srst_busy_i (srst_busy),
  .irq_id_i    (irq_id),
  .pend_irq_i  (pend_irq),
  .mask_all_i  (mask_all)
);

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  localparam int N  = 96;
  localparam int NB = N / 32;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         we_i = 1'b0;
  logic [9:0]   addr_i = '0;
  logic [31:0]  wdata_i = '0;
  logic [31:0]  rdata_o;
  logic [N-1:0] lines_i = '0;
  logic         irq_o, fiq_o;

  int checks = 0;
  int errors = 0;

  bit [31:0] m_mask [4];
  bit [31:0] m_trig [4];
  bit [5:0]  m_pri  [128];
  bit        m_fs   [128];

  always #10 clk = ~clk;

  prio_irq_ctrl #(.NUM_LINES(N), .REV_MAJOR(4'd5), .REV_MINOR(4'd0)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .lines_i(lines_i),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk); #1;
    we_i = 1'b0;
  endtask

  task automatic rd(logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic rchk(string req, logic [9:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  function automatic logic [9:0] bank_a(int b, int w);
    return 10'(32'h80 + 32 * b + 4 * w);
  endfunction

  function automatic bit pend_bit(int i);
    return (lines_i[i] | m_trig[i/32][i%32]) & !m_mask[i/32][i%32];
  endfunction

  function automatic logic [31:0] win(bit f);
    int best = -1;
    for (int i = 0; i < N; i++)
      if (pend_bit(i) && m_fs[i] == f && (best < 0 || m_pri[i] < m_pri[best])) best = i;
    return (best < 0) ? 32'h80 : 32'(best);
  endfunction

  function automatic logic [31:0] pend_word(int b, bit f);
    logic [31:0] r = '0;
    for (int k = 0; k < 32; k++) r[k] = pend_bit(b*32 + k) && (m_fs[b*32+k] == f);
    return r;
  endfunction

  task automatic model_reset();
    for (int b = 0; b < 4; b++) begin m_mask[b] = '1; m_trig[b] = '0; end
    for (int i = 0; i < 128; i++) begin m_pri[i] = '0; m_fs[i] = 1'b0; end
  endtask

  task automatic wr_lvl(int l, bit [5:0] p, bit f);
    wr(10'(32'h100 + 4*l), {24'b0, p, 1'b0, f});
    m_pri[l] = p; m_fs[l] = f;
  endtask

  task automatic rearm_check(string req);
    wr(10'h048, 32'h3);
    @(posedge clk);
    rchk(req, 10'h040, win(1'b0));
    rchk(req, 10'h044, win(1'b1));
    chk(req, {31'b0, irq_o}, {31'b0, win(1'b0) != 32'h80});
    chk(req, {31'b0, fiq_o}, {31'b0, win(1'b1) != 32'h80});
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // R1 reset state, R10 revision
    chk("R1 irq_o", {31'b0, irq_o}, 32'h0);
    chk("R1 fiq_o", {31'b0, fiq_o}, 32'h0);
    rchk("R1 status", 10'h014, 32'h1);
    rchk("R1 active irq", 10'h040, 32'h80);
    rchk("R1 active fiq", 10'h044, 32'h80);
    for (int b = 0; b < NB; b++) rchk("R1 mask", bank_a(b, 1), 32'hffffffff);
    rchk("R10 revision", 10'h000, 32'h50);

    // R2 mask aliases
    wr(bank_a(0, 2), 32'hffffffff);
    rchk("R2 clear alias", bank_a(0, 1), 32'h0);
    wr(bank_a(0, 3), 32'h000000f0);
    rchk("R2 set alias", bank_a(0, 1), 32'h000000f0);
    wr(bank_a(0, 2), 32'h00000030);
    rchk("R2 partial clear", bank_a(0, 1), 32'h000000c0);
    wr(bank_a(0, 3), 32'h0);
    wr(bank_a(0, 2), 32'h0);
    rchk("R2 zero bits no effect", bank_a(0, 1), 32'h000000c0);
    wr(bank_a(0, 1), 32'h0);
    rchk("R2 direct load", bank_a(0, 1), 32'h0);
    for (int b = 0; b < NB; b++) begin wr(bank_a(b, 1), 32'h0); m_mask[b] = '0; end

    // R6 level word format
    wr(10'(32'h100 + 4*5), 32'h45);
    rchk("R6 level readback", 10'(32'h100 + 4*5), 32'h45);
    wr(10'(32'h100 + 4*5), 32'hffffffff);
    rchk("R6 reserved bits zero", 10'(32'h100 + 4*5), 32'hfd);
    wr_lvl(5, 6'd0, 1'b0);

    // R3 software trigger on line 35
    wr(bank_a(1, 4), 32'h8); m_trig[1] = 32'h8;
    rchk("R3 trigger readback", bank_a(1, 4), 32'h8);
    rchk("R4 pending irq bank1", bank_a(1, 6), 32'h8);
    rearm_check("R3 triggered line wins");

    // R7 hold while a better line arrives
    wr(bank_a(0, 4), 32'h4); m_trig[0] = 32'h4;
    @(posedge clk);
    rchk("R7 held winner", 10'h040, 32'd35);
    chk("R7 output held", {31'b0, irq_o}, 32'h1);

    // R8 release then re-latch, R5 tie to lower number
    wr(10'h048, 32'h1);
    @(negedge clk);
    chk("R8 drop after rearm", {31'b0, irq_o}, 32'h0);
    @(posedge clk);
    rchk("R5 tie lower number", 10'h040, 32'd2);
    chk("R8 relatch", {31'b0, irq_o}, 32'h1);

    // R5 priority beats number, R4 fiq routing
    wr_lvl(2, 6'd9, 1'b0);
    wr_lvl(40, 6'd3, 1'b1);
    wr(bank_a(1, 4), 32'h100); m_trig[1] |= 32'h100;
    rchk("R4 pending fiq bank1", bank_a(1, 7), 32'h100);
    rearm_check("R5 priority order");

    // R8 rearm with nothing pending
    for (int b = 0; b < NB; b++) begin wr(bank_a(b, 5), 32'hffffffff); m_trig[b] = '0; end
    rearm_check("R8 empty rearm");

    // R9 soft reset
    wr(bank_a(2, 4), 32'h1); m_trig[2] = 32'h1;
    rearm_check("R9 prior latch");
    wr(10'h010, 32'h2);
    rchk("R9 status busy", 10'h014, 32'h0);
    rchk("R9 status done", 10'h014, 32'h1);
    model_reset();
    rchk("R9 mask set", bank_a(2, 1), 32'hffffffff);
    rchk("R9 trigger cleared", bank_a(2, 4), 32'h0);
    rchk("R9 level cleared", 10'(32'h100 + 4*40), 32'h0);
    chk("R9 irq dropped", {31'b0, irq_o}, 32'h0);

    // random rounds: R4 R5 R7 R8
    for (int i = 0; i < N; i++) wr_lvl(i, 6'($urandom % 4), 1'($urandom % 2));
    for (int it = 0; it < 40; it++) begin
      @(negedge clk);
      for (int b = 0; b < NB; b++) lines_i[b*32 +: 32] = $urandom & $urandom & $urandom;
      for (int b = 0; b < NB; b++) begin
        logic [31:0] m = $urandom | $urandom;
        logic [31:0] s = $urandom & $urandom;
        logic [31:0] c = $urandom & $urandom;
        wr(bank_a(b, 1), m); m_mask[b] = m;
        wr(bank_a(b, 4), s); m_trig[b] |= s;
        wr(bank_a(b, 5), c); m_trig[b] &= ~c;
      end
      for (int k = 0; k < 6; k++) wr_lvl($urandom % N, 6'($urandom % 4), 1'($urandom % 2));
      for (int b = 0; b < NB; b++) begin
        rchk("R4 random raw", bank_a(b, 0), lines_i[b*32 +: 32]);
        rchk("R4 random pend irq", bank_a(b, 6), pend_word(b, 1'b0));
        rchk("R4 random pend fiq", bank_a(b, 7), pend_word(b, 1'b1));
      end
      rearm_check("R5 random winner");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule